// File: doc/BRIEF.md
# Boot-Mode Capture and External Interrupt Front End

This block serves three shared, active-low external pins, labelled A, B and D. Each pin goes through a two-stage synchronizer to the system clock. While the active-low reset is held, the synchronized pin levels are copied into a 3-bit boot-mode register on every clock. The register freezes at the last value sampled before reset is released, and it keeps that value until the next reset.

Once reset is released, the same pins become maskable interrupt requests. Each source is set to level or falling-edge triggering through a small configuration write port.

- **Level mode.** The request follows the synchronized pin directly.
- **Edge mode.** A falling edge sets a pending bit. The bit stays set until the core acknowledges that source by index.

A fixed-priority picker reports one request line and a source index to the core. Two wake outputs are also produced:

- One ends a wait state when any unmasked request is active.
- The other ends a stop state, and only source A can drive it.

Top module: `xirq_ctrl`

## Requirements
- R1: While rst_n is low, boot_mode is loaded each clock with the synchronized pin levels (bit 0 = pin A, bit 1 = pin B, bit 2 = pin D, 1 = pin high). It keeps the value loaded at the last clock edge with rst_n low.
- R2: After reset is released, boot_mode does not change, whatever the pins or the other inputs do.
- R3: In reset, irq_req, wake_wait and wake_stop are 0 and irq_idx is 0. After reset, all sources are masked and all are in level mode.
- R4: A write with cfg_we=1 takes effect from the next clock. cfg_sel=0 loads cfg_data as the mask (1 = masked). cfg_sel=1 loads it as the trigger mode (1 = falling edge, 0 = level). The bit order is the same as in R1.
- R5: In level mode, an unmasked source is active while its pin is low. The request appears at the second rising edge after the pin changes, and it drops in the same way.
- R6: In edge mode, a high-to-low pin transition makes the source active from the third rising edge after the change. The source stays active after the pin returns high, until an acknowledge (ack_valid=1 with ack_idx equal to the source index) is taken at a clock edge. A new edge in the same cycle as the acknowledge wins.
- R7: An acknowledge naming another source, or an index of 3, leaves a pending source untouched.
- R8: A masked source never raises irq_req. A falling edge seen while masked is still held, and it raises the request once the source is unmasked.
- R9: irq_req is 1 when any source is active. irq_idx then gives the active source of highest priority, with A=0 over B=1 over D=2.
- R10: wake_wait equals core_waiting AND irq_req.
- R11: wake_stop is 1 only when core_stopped is 1 and source A is active. Sources B and D never drive it.
- R12: Pin edges that occur while reset is held do not leave a pending request behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| pin_n | input | 3 | Raw shared pins, active low (bit 0 = A, 1 = B, 2 = D) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = write mask, 1 = write trigger mode |
| cfg_data | input | 3 | Per-source configuration value |
| ack_valid | input | 1 | Core acknowledges a source |
| ack_idx | input | 2 | Index of the acknowledged source |
| core_waiting | input | 1 | Core is in the wait state |
| core_stopped | input | 1 | Core is in the stop state |
| boot_mode | output | 3 | Captured operating mode |
| irq_req | output | 1 | Interrupt request to the core |
| irq_idx | output | 2 | Index of the reported source |
| wake_wait | output | 1 | Wait-state exit |
| wake_stop | output | 1 | Stop-state exit |

## Verification
The bench releases reset with the pins held at a known pattern and then moves them. A design that keeps tracking the pins after reset, or that latches too early or too late, shows a wrong boot_mode.

Several cases target the pending bits:
- Edges during reset, which a careless design would leave pending.
- Acknowledges that name the wrong source or the unused index 3, which would wrongly clear a bit.
- A new edge arriving in the same cycle as its acknowledge, where a clear-wins design loses the edge.
- Edges that arrive while the source is masked, which a design might discard.

Simultaneous requests expose a wrong priority order. A pending B or D while the core is stopped would show a stop exit that must never occur.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  // configuration port target select
  typedef enum logic {
    CFG_MASK = 1'b0,
    CFG_TRIG = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int DEPTH = STAGES + 1;
  logic [W-1:0] chain [DEPTH];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) chain[g] <= d;
      end else begin : g_next
        always_ff @(posedge clk) chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q      = chain[STAGES-1];
  assign q_prev = chain[STAGES];
endmodule

// File: rtl/xirq_src.sv
module xirq_src (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_req,
  input  logic fall_ev,
  input  logic masked,
  input  logic edge_mode,
  input  logic ack_hit,
  output logic active
);
  logic pend_q;
  logic raw_req;

  // a new edge wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (edge_mode) pend_q <= (pend_q & ~ack_hit) | fall_ev;
    else                pend_q <= 1'b0;
  end

  assign raw_req = edge_mode ? pend_q : lvl_req;
  assign active  = rst_n & ~masked & raw_req;

  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && edge_mode && !ack_hit) |=> pend_q);
  assert_pend_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(fall_ev));
  assert_mask_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !active);
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb #(
  parameter int N  = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  act,
  output logic          any,
  output logic [IW-1:0] idx
);
  // lowest index has the highest priority
  function automatic logic [IW-1:0] first_set(input logic [N-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign any = |act;
  assign idx = first_set(act);

  assert_idx_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (int'(idx) < N));
  assert_top_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act[0] |-> (idx == '0));
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int NUM_SRC  = 3,
  parameter int SYNC_LEN = 2,
  parameter int STOP_SRC = 0,
  localparam int IW      = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pin_n,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [NUM_SRC-1:0] cfg_data,
  input  logic               ack_valid,
  input  logic [IW-1:0]      ack_idx,
  input  logic               core_waiting,
  input  logic               core_stopped,
  output logic [NUM_SRC-1:0] boot_mode,
  output logic               irq_req,
  output logic [IW-1:0]      irq_idx,
  output logic               wake_wait,
  output logic               wake_stop
);
  import xirq_pkg::*;

  logic [NUM_SRC-1:0] pin_q, pin_prev;
  logic [NUM_SRC-1:0] fall_ev, lvl_req;
  logic [NUM_SRC-1:0] mask_q, trig_q, mode_q;
  logic [NUM_SRC-1:0] active, ack_hit;

  xirq_sync #(.W(NUM_SRC), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .d(pin_n), .q(pin_q), .q_prev(pin_prev)
  );

  // named events for the source slices and assertions
  assign lvl_req = ~pin_q;
  assign fall_ev = pin_prev & ~pin_q & {NUM_SRC{rst_n}};

  // boot mode follows the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= pin_q;
  end
  assign boot_mode = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      trig_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel_e'(cfg_sel) == CFG_TRIG) trig_q <= cfg_data;
      else                                 mask_q <= cfg_data;
    end
  end

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign ack_hit[s] = ack_valid && (ack_idx == IW'(s));
      xirq_src u_src (
        .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req[s]), .fall_ev(fall_ev[s]),
        .masked(mask_q[s]), .edge_mode(trig_q[s]), .ack_hit(ack_hit[s]),
        .active(active[s])
      );
    end
  endgenerate

  xirq_arb #(.N(NUM_SRC), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .act(active), .any(irq_req), .idx(irq_idx)
  );

  assign wake_wait = core_waiting & irq_req;
  assign wake_stop = core_stopped & active[STOP_SRC];

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(boot_mode));
  assert_stop_only_a_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stop |-> (irq_req && irq_idx == IW'(STOP_SRC)));
  assert_wait_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_wait |-> (|active));
endmodule

// File: tb/xirq_ctrl_test.sv
module xirq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin_n = 3'b111;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [2:0] cfg_data = 3'b000;
  logic       ack_valid = 1'b0;
  logic [1:0] ack_idx = 2'd0;
  logic       core_waiting = 1'b0, core_stopped = 1'b0;
  logic [2:0] boot_mode;
  logic       irq_req, wake_wait, wake_stop;
  logic [1:0] irq_idx;

  int total = 0, bad = 0;
  bit done = 0, cmp_en = 0;
  string tag = "R3";

  // reference state
  logic [2:0] m_s1 = 3'b111, m_s2 = 3'b111, m_s3 = 3'b111;
  logic [2:0] m_mode = 0, m_mask = 3'b111, m_trig = 0, m_pend = 0;

  always #2 clk = ~clk;

  xirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .ack_valid(ack_valid), .ack_idx(ack_idx),
    .core_waiting(core_waiting), .core_stopped(core_stopped),
    .boot_mode(boot_mode), .irq_req(irq_req), .irq_idx(irq_idx),
    .wake_wait(wake_wait), .wake_stop(wake_stop)
  );

  function automatic logic [2:0] exp_act(input logic r);
    logic [2:0] a;
    for (int i = 0; i < 3; i++)
      a[i] = r & ~m_mask[i] & (m_trig[i] ? m_pend[i] : ~m_s2[i]);
    return a;
  endfunction

  function automatic logic [1:0] exp_pick(input logic [2:0] a);
    if (a[0]) return 2'd0;
    if (a[1]) return 2'd1;
    if (a[2]) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string t, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] p, input logic we = 0, input logic sel = 0,
                      input logic [2:0] dat = 0, input logic av = 0,
                      input logic [1:0] ai = 0, input logic w = 0, input logic s = 0);
    logic [2:0] a, fall, nxt;
    @(negedge clk);
    pin_n = p; cfg_we = we; cfg_sel = sel; cfg_data = dat;
    ack_valid = av; ack_idx = ai; core_waiting = w; core_stopped = s;
    #1;
    if (cmp_en) begin
      a = exp_act(rst_n);
      check(tag, {boot_mode, irq_req, irq_idx, wake_wait, wake_stop},
            {m_mode, |a, exp_pick(a), w & (|a), s & a[0]});
    end
    @(posedge clk); #1;
    if (!rst_n) begin
      m_pend = 0; m_mask = 3'b111; m_trig = 0; m_mode = m_s2;
    end else begin
      fall = m_s3 & ~m_s2;
      for (int i = 0; i < 3; i++)
        nxt[i] = m_trig[i] ? ((m_pend[i] & ~(av && ai == 2'(i))) | fall[i]) : 1'b0;
      m_pend = nxt;
      if (we) begin
        if (sel) m_trig = dat; else m_mask = dat;
      end
    end
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = p;
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd8123));
    // R12: edges during reset, then settle to 101 for the mode (R1)
    rst_n = 0;
    step(3'b111); step(3'b000); step(3'b111); step(3'b000);
    step(3'b101); step(3'b101); step(3'b101);
    cmp_en = 1;
    tag = "R3"; step(3'b101);
    check("R3", {irq_req, irq_idx, wake_wait, wake_stop}, 8'h0);
    rst_n = 1;
    tag = "R1"; step(3'b101);
    check("R1", boot_mode, 3'b101);
    tag = "R2"; step(3'b000); step(3'b111); step(3'b111);
    check("R2", boot_mode, 3'b101);
    // R12: unmask all in edge mode, nothing left from reset
    tag = "R12"; step(3'b111, 1, 1, 3'b111); step(3'b111, 1, 0, 3'b000);
    step(3'b111); step(3'b111);
    check("R12", irq_req, 1'b0);
    // R4/R5: level mode on all
    tag = "R4"; step(3'b111, 1, 1, 3'b000); step(3'b111);
    tag = "R5"; step(3'b110); step(3'b110); step(3'b110);
    check("R5", {irq_req, irq_idx}, {1'b1, 2'd0});
    step(3'b111); step(3'b111); step(3'b111);
    check("R5", irq_req, 1'b0);
    // R6/R7: edge mode, pulse on B
    tag = "R6"; step(3'b111, 1, 1, 3'b111); step(3'b101); step(3'b111);
    step(3'b111); step(3'b111);
    check("R6", {irq_req, irq_idx}, {1'b1, 2'd1});
    tag = "R7"; step(3'b111, 0, 0, 0, 1, 2'd0); step(3'b111, 0, 0, 0, 1, 2'd3);
    step(3'b111);
    check("R7", {irq_req, irq_idx}, {1'b1, 2'd1});
    tag = "R6"; step(3'b111, 0, 0, 0, 1, 2'd1); step(3'b111);
    check("R6", irq_req, 1'b0);
    // R8: masked edge on D held then released
    tag = "R8"; step(3'b111, 1, 0, 3'b100); step(3'b011); step(3'b111);
    step(3'b111); step(3'b111);
    check("R8", irq_req, 1'b0);
    step(3'b111, 1, 0, 3'b000); step(3'b111);
    check("R8", {irq_req, irq_idx}, {1'b1, 2'd2});
    step(3'b111, 0, 0, 0, 1, 2'd2);
    // R9/R10/R11: simultaneous edges
    tag = "R9"; step(3'b000); step(3'b111); step(3'b111);
    tag = "R11"; step(3'b111, 0, 0, 0, 1, 2'd0, 1, 1);
    check("R11", {irq_idx, wake_stop}, {2'd1, 1'b0});
    tag = "R10"; step(3'b111, 0, 0, 0, 1, 2'd1, 1, 1);
    check("R10", {wake_wait, irq_idx, wake_stop}, {1'b1, 2'd2, 1'b0});
    step(3'b111, 0, 0, 0, 1, 2'd2);
    // random phase
    tag = "R9";
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] p;
      p = pin_n;
      for (int b = 0; b < 3; b++) if ($urandom_range(0, 5) == 0) p[b] = ~p[b];
      if (k == 2000) begin
        tag = "R1"; rst_n = 0;
        step(3'b010); step(3'b010); step(3'b010);
        rst_n = 1; step(3'b010);
        check("R1", boot_mode, 3'b010);
        tag = "R9";
      end
      step(p, $urandom_range(0, 9) == 0, 1'($urandom), 3'($urandom),
           $urandom_range(0, 4) == 0, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule